// File: doc/BRIEF.md
# Compacted State Restore Sequencer

This block plans the restore of processor state components from a save area whose extended part is packed. A start pulse captures five 64-bit masks and the current in-use bitmap:

- the enabled-feature mask
- the supervisor-feature mask
- the per-request mask
- the header layout bitmap
- the header valid-data bitmap

From these masks the block works out which components are to be loaded from memory and which are to be put back to their initial value. It then steps through components 0 to 62, one per clock. For each component it issues a load or initialise command. A load command carries the byte offset of that component inside the area.

Components 0 and 1 sit in a fixed legacy region at offset 0. Extended components are packed from byte 576 upward, after the legacy region and the 64-byte header. The packing cursor moves only past components listed in the layout bitmap. A component listed there still takes up space when it is not being loaded. Per-component sizes come from a small table that is written before the walk through an address/data port.

When the walk ends, the block presents the updated in-use bitmap and the modified bitmap. Moving the data and the register files that receive it belong to neighbouring logic, which acts on the command stream.

Top module: `xstate_restore_seq`

## Requirements
- R1: A `start` pulse while `busy` is low captures all mask inputs and `inuse_in`. In the next cycle `busy` is 1 and `cmd_idx` is 0. A `start` pulse while `busy` is high is ignored.
- R2: The requested set is (`en_mask` OR `sup_mask`) AND `req_mask`. A component outside the requested set gets no command: `cmd_valid` is 0 in its step.
- R3: A component i is loaded (`cmd_valid`=1, `cmd_load`=1) when it is requested, its bit is set in `layout_bv`, its bit is set in `present_bv`, and i is not 63. Bit 63 of `layout_bv` is never treated as a component.
- R4: A requested component that is not loaded is initialised (`cmd_valid`=1, `cmd_load`=0). This covers a clear `present_bv` bit and a clear `layout_bv` bit (forced initialise). For components 0 and 1, load wins over initialise.
- R5: Load commands for components 0 and 1 carry `cmd_offset` 0.
- R6: The offset cursor is 576 at component 2. After the step for component i (2 to 62), the cursor grows by size entry i exactly when `layout_bv[i]` is 1, whether or not i is loaded. A load command for i carries the cursor value.
- R7: The walk takes one component per cycle in increasing order from 0 to 62. `done` is 1 only in the step for component 62. `busy` is 0 in the cycle after that step.
- R8: After the walk, the in-use bit of each loaded component is 1 and that of each initialised component is 0. Every other bit, including bit 63, keeps its captured `inuse_in` value.
- R9: After the walk, `modified_out` equals NOT the requested set over all 64 bits.
- R10: Size entry i (32 bits, address = component index 0..62) is written when `sz_we` is 1 while `busy` is low. A write while `busy` is high has no effect.
- R11: After reset, `busy`, `cmd_valid`, `done`, `inuse_out` and `modified_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk; captures the masks |
| en_mask | input | 64 | Enabled-feature mask |
| sup_mask | input | 64 | Supervisor-feature mask |
| req_mask | input | 64 | Per-request mask |
| layout_bv | input | 64 | Header layout bitmap (bit 63 is a format flag) |
| present_bv | input | 64 | Header valid-data bitmap |
| inuse_in | input | 64 | In-use bitmap before the walk |
| sz_we | input | 1 | Size table write strobe |
| sz_addr | input | 6 | Size table entry index |
| sz_data | input | 32 | Size in bytes |
| busy | output | 1 | Walk in progress |
| cmd_valid | output | 1 | Command present this cycle |
| cmd_load | output | 1 | 1 = load from area, 0 = initialise |
| cmd_idx | output | 6 | Component index of this step |
| cmd_offset | output | 32 | Byte offset for a load command |
| done | output | 1 | Final step of the walk |
| inuse_out | output | 64 | In-use bitmap |
| modified_out | output | 64 | Modified bitmap |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the final command and the `done` pulse. The bench compares `done` and the command tuple at step 62 against one expected entry. It then checks the bitmaps in the following cycle.

The second pair is a walk in progress and a fresh `start` together with a size-table write. The bench raises both in the middle of a walk with different values. It expects that walk to go on unchanged. A repeat of the same request afterwards must still produce the old offsets.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  typedef enum logic {
    CMD_INIT = 1'b0,
    CMD_LOAD = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/xrs_mask_calc.sv
module xrs_mask_calc #(
  parameter int NCOMP = 64
) (
  input  logic [NCOMP-1:0] en_mask,
  input  logic [NCOMP-1:0] sup_mask,
  input  logic [NCOMP-1:0] req_mask,
  input  logic [NCOMP-1:0] layout_bv,
  input  logic [NCOMP-1:0] present_bv,
  output logic [NCOMP-1:0] want,
  output logic [NCOMP-1:0] fmt,
  output logic [NCOMP-1:0] load_set,
  output logic [NCOMP-1:0] init_set
);
  localparam logic [NCOMP-1:0] FLAG_BIT = {1'b1, {(NCOMP-1){1'b0}}};

  always_comb begin
    want     = (en_mask | sup_mask) & req_mask;
    fmt      = layout_bv & ~FLAG_BIT;
    load_set = fmt & want & present_bv;
    init_set = (want & ~present_bv) | (want & ~fmt);
  end
endmodule

// File: rtl/xrs_size_table.sv
module xrs_size_table #(
  parameter int NENT = 63,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ent_q [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic hit;
    assign hit = we && (int'(waddr) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q[g] <= '0;
      else if (hit) ent_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NENT; k++) begin
      if (int'(raddr) == k) rdata = ent_q[k];
    end
  end
endmodule

// File: rtl/xrs_walker.sv
module xrs_walker #(
  parameter int IDXW      = 6,
  parameter int OFFW      = 32,
  parameter int FIRST_EXT = 2,
  parameter int LAST      = 62,
  parameter int BASE      = 576
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            fmt_bit,
  input  logic [OFFW-1:0] size,
  output logic            busy,
  output logic [IDXW-1:0] idx,
  output logic [OFFW-1:0] cursor,
  output logic            last_step
);
  localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(LAST);
  localparam logic [IDXW-1:0] FIRST_IDX = IDXW'(FIRST_EXT);
  localparam logic [OFFW-1:0] BASE_OFF  = OFFW'(BASE);

  logic            busy_d;
  logic [IDXW-1:0] idx_d;
  logic [OFFW-1:0] cur_d;
  logic            en;

  assign last_step = busy && (idx == LAST_IDX);

  always_comb begin
    busy_d = busy;
    idx_d  = idx;
    cur_d  = cursor;
    en     = 1'b0;
    if (go) begin
      en     = 1'b1;
      busy_d = 1'b1;
      idx_d  = '0;
      cur_d  = BASE_OFF;
    end else if (busy) begin
      en     = 1'b1;
      busy_d = !last_step;
      idx_d  = idx + 1'b1;
      if (idx >= FIRST_IDX && fmt_bit) cur_d = cursor + size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      cursor <= '0;
    end else if (en) begin
      busy   <= busy_d;
      idx    <= idx_d;
      cursor <= cur_d;
    end
  end
endmodule

// File: rtl/xstate_restore_seq.sv
module xstate_restore_seq #(
  parameter int NCOMP     = 64,
  parameter int OFFW      = 32,
  parameter int FIRST_EXT = 2,
  parameter int BASE      = 576,
  parameter int IDXW      = $clog2(NCOMP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NCOMP-1:0] en_mask,
  input  logic [NCOMP-1:0] sup_mask,
  input  logic [NCOMP-1:0] req_mask,
  input  logic [NCOMP-1:0] layout_bv,
  input  logic [NCOMP-1:0] present_bv,
  input  logic [NCOMP-1:0] inuse_in,
  input  logic             sz_we,
  input  logic [IDXW-1:0]  sz_addr,
  input  logic [OFFW-1:0]  sz_data,
  output logic             busy,
  output logic             cmd_valid,
  output logic             cmd_load,
  output logic [IDXW-1:0]  cmd_idx,
  output logic [OFFW-1:0]  cmd_offset,
  output logic             done,
  output logic [NCOMP-1:0] inuse_out,
  output logic [NCOMP-1:0] modified_out
);
  import xrs_pkg::*;

  localparam int LAST = NCOMP - 2;
  localparam logic [IDXW-1:0] FIRST_IDX = IDXW'(FIRST_EXT);

  logic [NCOMP-1:0] want_c, fmt_c, load_c, init_c;
  logic [NCOMP-1:0] want_q, fmt_q, load_q, init_q;
  logic [NCOMP-1:0] inuse_d, mod_d;
  logic [OFFW-1:0]  size_rd, cursor;
  logic             go, step_last, cap_en, bits_en;
  cmd_kind_e        kind;

  assign go = start && !busy;

  xrs_mask_calc #(.NCOMP(NCOMP)) u_mask (
    .en_mask(en_mask), .sup_mask(sup_mask), .req_mask(req_mask),
    .layout_bv(layout_bv), .present_bv(present_bv),
    .want(want_c), .fmt(fmt_c), .load_set(load_c), .init_set(init_c)
  );

  xrs_size_table #(.NENT(LAST + 1), .DW(OFFW), .AW(IDXW)) u_size (
    .clk(clk), .rst_n(rst_n), .we(sz_we && !busy), .waddr(sz_addr),
    .wdata(sz_data), .raddr(cmd_idx), .rdata(size_rd)
  );

  xrs_walker #(.IDXW(IDXW), .OFFW(OFFW), .FIRST_EXT(FIRST_EXT),
               .LAST(LAST), .BASE(BASE)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .fmt_bit(fmt_q[cmd_idx]),
    .size(size_rd), .busy(busy), .idx(cmd_idx), .cursor(cursor),
    .last_step(step_last)
  );

  // Command tuple for the current step
  always_comb begin
    kind       = load_q[cmd_idx] ? CMD_LOAD : CMD_INIT;
    cmd_valid  = busy && (load_q[cmd_idx] || init_q[cmd_idx]);
    cmd_load   = (kind == CMD_LOAD);
    cmd_offset = (cmd_idx < FIRST_IDX) ? '0 : cursor;
    done       = step_last;
  end

  // Next state of the tracking bitmaps
  always_comb begin
    inuse_d = inuse_out;
    mod_d   = modified_out;
    cap_en  = go;
    bits_en = go || busy;
    if (go) begin
      inuse_d = inuse_in;
    end else if (busy) begin
      if (load_q[cmd_idx])      inuse_d[cmd_idx] = 1'b1;
      else if (init_q[cmd_idx]) inuse_d[cmd_idx] = 1'b0;
      if (step_last)            mod_d = ~want_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      fmt_q  <= '0;
      load_q <= '0;
      init_q <= '0;
    end else if (cap_en) begin
      want_q <= want_c;
      fmt_q  <= fmt_c;
      load_q <= load_c;
      init_q <= init_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inuse_out    <= '0;
      modified_out <= '0;
    end else if (bits_en) begin
      inuse_out    <= inuse_d;
      modified_out <= mod_d;
    end
  end
endmodule

// File: rtl/xrs_seq_chk.sv
module xrs_seq_chk #(
  parameter int NCOMP = 64,
  parameter int OFFW  = 32,
  parameter int BASE  = 576,
  parameter int IDXW  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             cmd_valid,
  input logic [IDXW-1:0]  cmd_idx,
  input logic [OFFW-1:0]  cmd_offset,
  input logic             done,
  input logic [NCOMP-1:0] want_q,
  input logic [NCOMP-1:0] modified_out
);
  // R1
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cmd_idx == '0));
  // R2
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
  // R5
  legacy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_idx < IDXW'(2)) |-> cmd_offset == '0);
  // R6
  first_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_idx == IDXW'(2)) |-> cmd_offset == OFFW'(BASE));
  // R7
  step_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && cmd_idx == $past(cmd_idx) + 1'b1));
  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R9
  mod_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> modified_out == ~$past(want_q));
endmodule

bind xstate_restore_seq xrs_seq_chk #(.NCOMP(NCOMP), .OFFW(OFFW), .BASE(BASE), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cmd_valid(cmd_valid),
  .cmd_idx(cmd_idx), .cmd_offset(cmd_offset), .done(done), .want_q(want_q),
  .modified_out(modified_out)
);

// File: tb/tb_xstate_restore_seq.sv
`timescale 1ns/1ps
module tb_xstate_restore_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, sz_we;
  logic [63:0] en_mask, sup_mask, req_mask, layout_bv, present_bv, inuse_in;
  logic [5:0]  sz_addr;
  logic [31:0] sz_data;
  logic        busy, cmd_valid, cmd_load, done;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_offset;
  logic [63:0] inuse_out, modified_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int unsigned m_size[63];
  bit          e_valid[63];
  bit          e_load[63];
  int unsigned e_off[63];
  bit [63:0]   e_inuse, e_mod;

  always #10 clk = ~clk;

  xstate_restore_seq dut (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr_size(input int a, input int unsigned d);
    @(negedge clk);
    sz_we = 1'b1; sz_addr = 6'(a); sz_data = d;
    @(negedge clk);
    sz_we = 1'b0;
    if (a < 63) m_size[a] = d;
  endtask

  task automatic model(input bit [63:0] en, sup, rq, lay, pres, iu);
    bit [63:0] want, fm, ld, it;
    int unsigned cur;
    want = (en | sup) & rq;
    fm   = lay;
    fm[63] = 1'b0;
    ld   = fm & want & pres;
    it   = (want & ~pres) | (want & ~fm);
    cur  = 576;
    e_inuse = iu;
    for (int k = 0; k < 63; k++) begin
      e_valid[k] = ld[k] | it[k];
      e_load[k]  = ld[k];
      e_off[k]   = (k < 2) ? 0 : cur;
      if (k >= 2 && fm[k]) cur = cur + m_size[k];
      if (ld[k]) e_inuse[k] = 1'b1;
      else if (it[k]) e_inuse[k] = 1'b0;
    end
    e_mod = ~want;
  endtask

  task automatic run(input bit [63:0] en, sup, rq, lay, pres, iu, input bit disturb);
    model(en, sup, rq, lay, pres, iu);
    @(negedge clk);
    en_mask = en; sup_mask = sup; req_mask = rq;
    layout_bv = lay; present_bv = pres; inuse_in = iu;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 63; k++) begin
      chk(busy == 1'b1, "R1", "busy during walk", 64'(busy), 64'd1);
      chk(cmd_idx == 6'(k), "R7", "step index", 64'(cmd_idx), 64'(k));
      chk(cmd_valid == e_valid[k], "R2", $sformatf("valid idx %0d", k), 64'(cmd_valid), 64'(e_valid[k]));
      if (e_valid[k])
        chk(cmd_load == e_load[k], e_load[k] ? "R3" : "R4", $sformatf("kind idx %0d", k), 64'(cmd_load), 64'(e_load[k]));
      if (e_valid[k] && e_load[k])
        chk(cmd_offset == e_off[k], (k < 2) ? "R5" : "R6", $sformatf("offset idx %0d", k), 64'(cmd_offset), 64'(e_off[k]));
      chk(done == (k == 62), "R7", "done timing", 64'(done), 64'(k == 62));
      if (disturb && k == 10) begin
        // R1 and R10: start and size write while busy must be ignored
        start = 1'b1; en_mask = '0; sup_mask = '0; req_mask = '0;
        sz_we = 1'b1; sz_addr = 6'd5; sz_data = 32'd4000;
      end
      if (disturb && k == 11) begin
        start = 1'b0; sz_we = 1'b0;
      end
      @(negedge clk);
    end
    chk(busy == 1'b0, "R7", "idle after walk", 64'(busy), 64'd0);
    chk(inuse_out == e_inuse, "R8", "in-use bitmap", inuse_out, e_inuse);
    chk(modified_out == e_mod, "R9", "modified bitmap", modified_out, e_mod);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; sz_we = 1'b0; sz_addr = '0; sz_data = '0;
    en_mask = '0; sup_mask = '0; req_mask = '0; layout_bv = '0;
    present_bv = '0; inuse_in = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 0, "R11", "reset busy", 64'(busy), 0);
    chk(cmd_valid == 0, "R11", "reset valid", 64'(cmd_valid), 0);
    chk(done == 0, "R11", "reset done", 64'(done), 0);
    chk(inuse_out == 0, "R11", "reset inuse", inuse_out, 0);
    chk(modified_out == 0, "R11", "reset modified", modified_out, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 63; i++) m_size[i] = 0;
    for (int i = 0; i < 63; i++) wr_size(i, 32'(64 * ((i % 5) + 1)));
    // R3 R6: everything requested and present
    run('1, '0, '1, '1, '1, '0, 1'b0);
    // R2 R4: partial request, partial present
    run(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0F00, 64'hFFFF_FFFF_FFFF_0F5F,
        64'h8000_0000_0000_0F3F, 64'h0000_0000_0000_0A37, 64'hF0F0_F0F0_F0F0_F0F0, 1'b0);
    // R4 forced initialise for components missing from the layout; flag bit clear
    run('1, '0, '1, 64'h0000_0000_FFFF_0003, '1, '1, 1'b0);
    // R1 R10: start and size write during a walk
    run(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0F00, 64'hFFFF_FFFF_FFFF_0F5F,
        64'h8000_0000_0000_0F3F, 64'h0000_0000_0000_0A37, 64'h0, 1'b1);
    run(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0F00, 64'hFFFF_FFFF_FFFF_0F5F,
        64'h8000_0000_0000_0F3F, 64'h0000_0000_0000_0A37, 64'h0, 1'b0);
    // R6: new sizes, sparse present bitmap, cursor advances over skipped entries
    for (int i = 2; i < 63; i++) wr_size(i, 32'(i * 16 + 8));
    run(64'h00FF_FFFF_FFFF_FFFF, 64'h7F00_0000_0000_0000, '1,
        64'hF5F5_F5F5_F5F5_F5F5, 64'hAAAA_AAAA_AAAA_AAAA, 64'h1234_5678_9ABC_DEF0, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule